// File: doc/BRIEF.md
# Dual-Clock Two-Port Shared Memory

This block is a word-addressed memory shared by two access ports, A and B. Each port has its own clock and its own synchronous active-low reset. Each port can read or write on every rising edge of its clock, independently of the other port. Software-visible state is limited to the stored words and the two registered read outputs.

On each edge a port takes one operation from a 2-bit opcode, together with an address and write data. The port's data output is a register in that port's clock domain, and it changes one edge after the operation. A write returns the written data on the same port, so the port sees its new data first. A read returns the stored word. A no-op leaves the output register as it was.

The storage is held as two replica banks, one written from each clock domain. A pair of per-word tags records which bank holds the newest value. As a result, no storage register is written from two clocks.

Top module: `dpram_dual_clk`

## Requirements
- R1: While a port's reset is low, that port's data output is 0 on the next rising edge of its clock. After both resets have been applied, every word reads as 0 until it is written.
- R2: Opcode 2'b01 (read) at a rising edge makes the port's output, after that edge, equal to the word stored at the given address.
- R3: Opcode 2'b10 (write) at a rising edge stores the write data at the given address. After that edge, the same port's output shows the written data.
- R4: Opcode 2'b00 (no-op) and opcode 2'b11 (reserved) leave the port's output unchanged and do not modify any stored word.
- R5: A word written by one port is returned by a read on the other port at any edge of the reader's clock that comes strictly later than the write edge.
- R6: A read on a port, at the edge right after that port wrote the same address, returns the newly written data.
- R7: When both ports write the same address at distinct edges, the write at the later edge is the one kept.
- R8: A read on one port at the same instant as a write to that address on the other port gives an undefined output. Writes to one address from both ports at the same instant leave that word undefined.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A synchronous reset, active low |
| op_a | input | 2 | Port A opcode: 00 no-op, 01 read, 10 write, 11 reserved (no-op) |
| addr_a | input | ADDR_W | Port A word address |
| wdata_a | input | DATA_W | Port A write data |
| rdata_a | output | DATA_W | Port A registered data output |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B synchronous reset, active low |
| op_b | input | 2 | Port B opcode, same encoding as op_a |
| addr_b | input | ADDR_W | Port B word address |
| wdata_b | input | DATA_W | Port B write data |
| rdata_b | output | DATA_W | Port B registered data output |

## Verification
The assertions assume that each port's opcode, address and data are stable around its own rising edge. They also assume that write data is known whenever the opcode is a write. They make no claim about values that depend on cross-port collisions.

The stimulus drives each port only on the falling edge of its own clock. The two clocks have unrelated periods of 8 ns and 11 ns. In the random phase, port A writes only even addresses and port B writes only odd addresses, so simultaneous writes to one word cannot occur. The reference model skips any read whose address the other port wrote at the same instant.

// File: rtl/tdp_pkg.sv
`timescale 1ns/1ps
// Shared opcode type for the dual-clock two-port memory.
package tdp_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_RSVD  = 2'b11
    } tdp_op_e;

endpackage

// File: rtl/tdp_op_decode.sv
`timescale 1ns/1ps
// Opcode decoder for one port.
// Turns the 2-bit opcode into a read strobe and a write strobe.
// Assumes: the reserved code is treated exactly like a no-op.
module tdp_op_decode (
    input  logic [1:0] op,
    output logic       rd_en,
    output logic       wr_en
);
    import tdp_pkg::*;

    // Map each opcode to the strobes it raises.
    always_comb begin
        rd_en = 1'b0;
        wr_en = 1'b0;
        unique case (tdp_op_e'(op))
            OP_READ:  rd_en = 1'b1;
            OP_WRITE: wr_en = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/tdp_bank.sv
`timescale 1ns/1ps
// Replica storage bank owned by one port's clock domain.
// Holds a full copy of the words that this port has written, plus one tag bit per word.
// LEADS = 1 makes a write set the local tag different from the peer tag.
// LEADS = 0 makes a write set the local tag equal to the peer tag.
// The read side compares the two tags to pick the newest copy.
// Assumes: peer_tag comes from the other domain and is only sampled here.
module tdp_bank #(
    parameter int WORDS  = 32,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5,
    parameter bit LEADS  = 1'b1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              wdata,
    input  logic [WORDS-1:0]               peer_tag,
    output logic [WORDS-1:0][DATA_W-1:0]   words,
    output logic [WORDS-1:0]               tag
);
    logic in_range;
    logic next_tag;

    assign in_range = (32'(addr) < WORDS);

    // Pick the tag rule for this side of the ownership pair.
    generate
        if (LEADS) begin : g_lead
            assign next_tag = ~peer_tag[addr];
        end else begin : g_follow
            assign next_tag = peer_tag[addr];
        end
    endgenerate

    // Store write data and claim ownership of the written word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words <= '0;
            tag   <= '0;
        end else if (wr_en && in_range) begin
            words[addr] <= wdata;
            tag[addr]   <= next_tag;
        end
    end
endmodule

// File: rtl/tdp_read_select.sv
`timescale 1ns/1ps
// Read multiplexer for one port.
// Returns the newest copy of the addressed word.
// Differing tags mean bank 0 (port A) wrote the word last; equal tags mean bank 1 (port B) did.
// Assumes: out-of-range addresses read as zero.
module tdp_read_select #(
    parameter int WORDS  = 32,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0]              addr,
    input  logic [WORDS-1:0][DATA_W-1:0]   words0,
    input  logic [WORDS-1:0][DATA_W-1:0]   words1,
    input  logic [WORDS-1:0]               tag0,
    input  logic [WORDS-1:0]               tag1,
    output logic [DATA_W-1:0]              rd_word
);
    // Choose the bank whose tag marks it as the last writer.
    always_comb begin
        rd_word = '0;
        if (32'(addr) < WORDS) begin
            rd_word = (tag0[addr] != tag1[addr]) ? words0[addr] : words1[addr];
        end
    end
endmodule

// File: rtl/tdp_out_reg.sv
`timescale 1ns/1ps
// Output register for one port.
// On a write it loads the write data (the port sees its new data first).
// On a read it loads the selected word. Otherwise it holds its value.
// Assumes: rd_en and wr_en are never high together.
module tdp_out_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] q
);
    // Update the port output one edge after the operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            q <= wdata;
        end else if (rd_en) begin
            q <= rd_word;
        end
    end
endmodule

// File: rtl/dpram_dual_clk.sv
`timescale 1ns/1ps
// Dual-clock two-port shared memory.
// Each port has its own clock, its own reset, an opcode decoder, a storage replica
// and an output register. Port A writes land in bank 0 and port B writes in bank 1.
// Per-word tag pairs track the newest copy, so every register has one writing clock.
// Assumes: simultaneous cross-port access to one word is the user's responsibility.
module dpram_dual_clk #(
    parameter int WORDS  = 32,
    parameter int DATA_W = 8,
    localparam int ADDR_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk_a,
    input  logic              rst_a_n,
    input  logic [1:0]        op_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [DATA_W-1:0] wdata_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic              clk_b,
    input  logic              rst_b_n,
    input  logic [1:0]        op_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [DATA_W-1:0] wdata_b,
    output logic [DATA_W-1:0] rdata_b
);
    localparam int PORTS = 2;

    logic [PORTS-1:0]                         clk_p;
    logic [PORTS-1:0]                         rst_p;
    logic [PORTS-1:0][1:0]                    op_p;
    logic [PORTS-1:0][ADDR_W-1:0]             addr_p;
    logic [PORTS-1:0][DATA_W-1:0]             wdata_p;
    logic [PORTS-1:0][DATA_W-1:0]             rdata_p;
    logic [PORTS-1:0][DATA_W-1:0]             sel_p;
    logic [PORTS-1:0]                         rd_en_p;
    logic [PORTS-1:0]                         wr_en_p;
    logic [PORTS-1:0][WORDS-1:0][DATA_W-1:0]  bank_words;
    logic [PORTS-1:0][WORDS-1:0]              bank_tag;

    assign clk_p   = {clk_b, clk_a};
    assign rst_p   = {rst_b_n, rst_a_n};
    assign op_p    = {op_b, op_a};
    assign addr_p  = {addr_b, addr_a};
    assign wdata_p = {wdata_b, wdata_a};
    assign rdata_a = rdata_p[0];
    assign rdata_b = rdata_p[1];

    // One identical slice per port; port 0 is the tag leader.
    generate
        for (genvar p = 0; p < PORTS; p++) begin : g_port
            tdp_op_decode u_dec (
                .op    (op_p[p]),
                .rd_en (rd_en_p[p]),
                .wr_en (wr_en_p[p])
            );

            tdp_bank #(
                .WORDS  (WORDS),
                .DATA_W (DATA_W),
                .ADDR_W (ADDR_W),
                .LEADS  (p == 0)
            ) u_bank (
                .clk      (clk_p[p]),
                .rst_n    (rst_p[p]),
                .wr_en    (wr_en_p[p]),
                .addr     (addr_p[p]),
                .wdata    (wdata_p[p]),
                .peer_tag (bank_tag[PORTS-1-p]),
                .words    (bank_words[p]),
                .tag      (bank_tag[p])
            );

            tdp_read_select #(
                .WORDS  (WORDS),
                .DATA_W (DATA_W),
                .ADDR_W (ADDR_W)
            ) u_sel (
                .addr    (addr_p[p]),
                .words0  (bank_words[0]),
                .words1  (bank_words[1]),
                .tag0    (bank_tag[0]),
                .tag1    (bank_tag[1]),
                .rd_word (sel_p[p])
            );

            tdp_out_reg #(
                .DATA_W (DATA_W)
            ) u_out (
                .clk     (clk_p[p]),
                .rst_n   (rst_p[p]),
                .rd_en   (rd_en_p[p]),
                .wr_en   (wr_en_p[p]),
                .wdata   (wdata_p[p]),
                .rd_word (sel_p[p]),
                .q       (rdata_p[p])
            );
        end
    endgenerate
endmodule

// File: rtl/tdp_checker.sv
`timescale 1ns/1ps
// Port-level checks for the dual-clock two-port memory, bound to the top module.
// Assumes: port inputs are stable around their own clock's rising edge.
module tdp_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk_a,
    input logic              rst_a_n,
    input logic [1:0]        op_a,
    input logic [DATA_W-1:0] wdata_a,
    input logic [DATA_W-1:0] rdata_a,
    input logic              clk_b,
    input logic              rst_b_n,
    input logic [1:0]        op_b,
    input logic [DATA_W-1:0] wdata_b,
    input logic [DATA_W-1:0] rdata_b
);
    logic rst_seen_a;
    logic rst_seen_b;

    // Remember that port A's previous edge was taken in reset.
    always_ff @(posedge clk_a) rst_seen_a <= !rst_a_n;
    // Remember that port B's previous edge was taken in reset.
    always_ff @(posedge clk_b) rst_seen_b <= !rst_b_n;

    // R3
    wr_echo_a_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (op_a == 2'b10) |=> (rdata_a == $past(wdata_a)));

    // R3
    wr_echo_b_chk: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (op_b == 2'b10) |=> (rdata_b == $past(wdata_b)));

    // R4
    idle_hold_a_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (op_a == 2'b00 || op_a == 2'b11) |=> $stable(rdata_a));

    // R4
    idle_hold_b_chk: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (op_b == 2'b00 || op_b == 2'b11) |=> $stable(rdata_b));

    // Port A output must be zero after an edge taken in reset.
    always @(negedge clk_a) begin
        if (rst_seen_a == 1'b1) begin
            // R1
            rst_zero_a_chk: assert (rdata_a == '0);
        end
    end

    // Port B output must be zero after an edge taken in reset.
    always @(negedge clk_b) begin
        if (rst_seen_b == 1'b1) begin
            // R1
            rst_zero_b_chk: assert (rdata_b == '0);
        end
    end
endmodule

bind dpram_dual_clk tdp_checker #(.DATA_W(DATA_W)) u_tdp_checker (
    .clk_a   (clk_a),
    .rst_a_n (rst_a_n),
    .op_a    (op_a),
    .wdata_a (wdata_a),
    .rdata_a (rdata_a),
    .clk_b   (clk_b),
    .rst_b_n (rst_b_n),
    .op_b    (op_b),
    .wdata_b (wdata_b),
    .rdata_b (rdata_b)
);

// File: tb/test_dpram_dual_clk.sv
`timescale 1ns/1ps
// Bench for the dual-clock two-port memory.
// A behavioural model (a word array plus per-port write times) predicts each port's
// output on every edge. The output is compared on the following falling edge.
module test_dpram_dual_clk;
    localparam int WORDS  = 32;
    localparam int DATA_W = 8;
    localparam int ADDR_W = $clog2(WORDS);
    localparam real PER_A = 8.0;
    localparam real PER_B = 11.0;

    logic clk_a = 1'b0;
    logic clk_b = 1'b0;
    logic [1:0]        rst_s  [2];
    logic [1:0]        op_s   [2];
    logic [ADDR_W-1:0] addr_s [2];
    logic [DATA_W-1:0] wdata_s[2];
    logic [DATA_W-1:0] rdata_a;
    logic [DATA_W-1:0] rdata_b;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [DATA_W-1:0] model [WORDS];
    real               last_w[2][WORDS];
    logic [DATA_W-1:0] exp_q [2];
    bit                known [2];
    string             req_s [2];

    always #(PER_A / 2.0) clk_a = ~clk_a;
    always #(PER_B / 2.0) clk_b = ~clk_b;

    dpram_dual_clk #(.WORDS(WORDS), .DATA_W(DATA_W)) i_dpram_dual_clk (
        .clk_a   (clk_a),
        .rst_a_n (rst_s[0][0]),
        .op_a    (op_s[0]),
        .addr_a  (addr_s[0]),
        .wdata_a (wdata_s[0]),
        .rdata_a (rdata_a),
        .clk_b   (clk_b),
        .rst_b_n (rst_s[1][0]),
        .op_b    (op_s[1]),
        .addr_b  (addr_s[1]),
        .wdata_b (wdata_s[1]),
        .rdata_b (rdata_b)
    );

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Model one rising edge of port p: writes apply at the edge, reads after all same-time writes.
    task automatic port_edge(input int p);
        real t;
        int o;
        logic [1:0] op;
        int a;
        t  = $realtime;
        o  = 1 - p;
        op = op_s[p];
        a  = int'(addr_s[p]);
        if (!rst_s[p][0]) begin
            exp_q[p] = '0; known[p] = 1'b1; req_s[p] = "R1";
            return;
        end
        if (op == 2'b10) begin
            model[a] = wdata_s[p];
            last_w[p][a] = t;
            exp_q[p] = wdata_s[p]; known[p] = 1'b1; req_s[p] = "R3";
        end
        #1;
        if (op == 2'b01) begin
            if (last_w[o][a] > t - 0.25) begin
                known[p] = 1'b0;   // R8: cross-port collision, output undefined
            end else begin
                exp_q[p] = model[a]; known[p] = 1'b1;
                if (last_w[0][a] >= 0.0 && last_w[1][a] >= 0.0) req_s[p] = "R7";
                else if (last_w[o][a] >= 0.0) req_s[p] = "R5";
                else if (last_w[p][a] >= t - (p == 0 ? PER_A : PER_B) - 0.25) req_s[p] = "R6";
                else if (last_w[p][a] >= 0.0) req_s[p] = "R2";
                else req_s[p] = "R1";
            end
        end else if (op != 2'b10) begin
            req_s[p] = "R4";
        end
    endtask

    // Compare port p's output against the model, away from the active edge.
    task automatic port_check(input int p, input logic [DATA_W-1:0] act);
        if (done || !known[p]) return;
        n_chk++;
        if (act !== exp_q[p]) begin
            n_fail++;
            $display("FAIL %s port %0d: rdata=%h expected %h at %0t", req_s[p], p, act, exp_q[p], $time);
        end
    endtask

    always @(posedge clk_a) port_edge(0);
    always @(posedge clk_b) port_edge(1);
    always @(negedge clk_a) port_check(0, rdata_a);
    always @(negedge clk_b) port_check(1, rdata_b);

    // Issue one operation on port p at its next falling edge.
    task automatic drive(input int p, input logic [1:0] op, input int a, input logic [DATA_W-1:0] d);
        if (p == 0) @(negedge clk_a);
        else        @(negedge clk_b);
        op_s[p]    = op;
        addr_s[p]  = ADDR_W'(a);
        wdata_s[p] = d;
    endtask

    // Random traffic; writes use addresses of parity p so both ports never write one word.
    task automatic rand_port(input int p);
        for (int k = 0; k < 400; k++) begin
            int r;
            int a;
            r = int'($urandom % 8);
            a = int'($urandom % WORDS);
            if (r == 3 || r == 4)
                drive(p, 2'b10, (a & ~1) | p, DATA_W'($urandom));
            else if (r == 5)
                drive(p, 2'b00, a, DATA_W'($urandom));
            else if (r == 6)
                drive(p, 2'b11, a, DATA_W'($urandom));
            else
                drive(p, 2'b01, a, '0);
        end
        drive(p, 2'b00, 0, '0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * PER_A);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        report();
    end

    // Main sequence.
    initial begin
        for (int i = 0; i < WORDS; i++) begin
            model[i] = '0; last_w[0][i] = -1.0e9; last_w[1][i] = -1.0e9;
        end
        for (int p = 0; p < 2; p++) begin
            rst_s[p] = 2'b00; op_s[p] = 2'b00; addr_s[p] = '0; wdata_s[p] = '0;
            known[p] = 1'b0; exp_q[p] = '0; req_s[p] = "R1";
        end
        #60;
        @(negedge clk_a) rst_s[0] = 2'b01;
        @(negedge clk_b) rst_s[1] = 2'b01;

        // R1: every word reads zero after reset
        for (int i = 0; i < WORDS; i++) drive(0, 2'b01, i, '0);
        // R3 echo, then R6 same-port read of the fresh word
        drive(0, 2'b10, 3, 8'h5A);
        drive(0, 2'b01, 3, '0);
        // R4: both no-op codes hold the output; reserved code must not write word 7
        drive(0, 2'b00, 9, 8'h11);
        drive(0, 2'b11, 7, 8'hFF);
        drive(0, 2'b01, 7, '0);
        drive(0, 2'b00, 0, '0);
        // R5: port B sees port A's word
        drive(1, 2'b01, 3, '0);
        // R3 on port B, then R7: later write from B replaces A's word
        drive(1, 2'b10, 3, 8'hC3);
        drive(1, 2'b00, 0, '0);
        drive(0, 2'b01, 3, '0);
        drive(0, 2'b10, 3, 8'h27);
        drive(0, 2'b00, 0, '0);
        drive(1, 2'b01, 3, '0);
        drive(1, 2'b00, 0, '0);

        // Mixed random traffic on both clocks at once
        fork
            rand_port(0);
            rand_port(1);
        join

        // Sweep every word from both ports after traffic settles
        for (int i = 0; i < WORDS; i++) drive(0, 2'b01, i, '0);
        drive(0, 2'b00, 0, '0);
        for (int i = 0; i < WORDS; i++) drive(1, 2'b01, i, '0);
        drive(1, 2'b00, 0, '0);
        repeat (4) @(negedge clk_b);
        done = 1'b1;
        report();
    end
endmodule